// File: doc/BRIEF.md
# Flooring Integer Divider

This block divides an integer dividend by an integer divisor and returns a quotient rounded toward negative infinity, together with the matching modulo whose sign follows the divisor. Each operand has its own width and signedness flag, and the result has its own width. If both operands are declared signed, the unit works in floor mode. If either operand is declared unsigned, both operands are read as unsigned and the unit behaves as an ordinary truncating divider.

Floor semantics come from a plain truncating divider. When the operand signs differ and the dividend is nonzero, the dividend is corrected before the divide: the divisor, moved one step toward zero, is subtracted from it. All internal arithmetic runs one bit wider than the widest of the three widths, so the correction cannot overflow. The divide is a restoring loop on magnitudes that retires one bit per cycle. A one-cycle start pulse launches an operation, and a one-cycle done pulse marks valid results. A zero divisor skips the loop and raises a flag.

Top module: `floor_divider`

## Requirements
- R1: With both operands signed and a nonzero divisor, the quotient equals floor(A / B), for example -7 / 2 gives -4 and 7 / -2 gives -4.
- R2: With both operands signed and a nonzero divisor, the remainder equals A - B*Q. It is either zero or has the divisor's sign, and its magnitude is below |B|, for example -7 mod 2 gives 1 and 7 mod -2 gives -1.
- R3: If either operand is declared unsigned, both operands are read as unsigned, the quotient is A / B truncated and the remainder is A % B.
- R4: Quotient and remainder are the low Y_WIDTH bits, in two's complement, of the exact result. A result that needs more bits wraps.
- R5: A zero divisor sets divByZero, forces the quotient to all ones and returns the dividend as the remainder (sign- or zero-extended per mode, low Y_WIDTH bits). divByZero is 0 for every nonzero divisor.
- R6: Let W = max(A_WIDTH, B_WIDTH, Y_WIDTH) + 1. done is high for exactly one cycle. It appears W+1 clock edges after the edge that accepts start, or one edge after it when the divisor is zero.
- R7: busy is high from the accepting edge until done appears. A start pulse or operand change while busy has no effect on the running result or its timing.
- R8: quotient, remainder and divByZero keep their values until the next done.
- R9: After reset, busy, done, divByZero, quotient and remainder are all 0.
- R10: The most negative signed dividend divided by -1 gives the exact positive quotient with no overflow inside the unit, for example -8 / -1 gives 8 with 4-bit operands and a 5-bit result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, sampled while idle |
| dividend | input | A_WIDTH | Operand A |
| divisor | input | B_WIDTH | Operand B |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| quotient | output | Y_WIDTH | Quotient |
| remainder | output | Y_WIDTH | Modulo |
| divByZero | output | 1 | Divisor was zero |

## Verification
The assertions assume that the operands are stable at the edge that accepts start, and that start is a clean synchronous level. They make no assumption about the operands after that edge, because the unit captures everything it needs when it accepts start. The stimulus drives start and the operands only on falling clock edges and holds them through the accepting edge. One test also toggles start and the operands in the middle of an operation, to confirm that activity during a run has no effect. Both small configurations are swept over every dividend and divisor value, including zero divisors and the most negative dividend.

// File: rtl/floordiv_pkg.sv
package floordiv_pkg;
  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } divStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIX} divState_t;
endpackage

// File: rtl/floordiv_prep.sv
module floordiv_prep #(
  parameter int A_WIDTH = 8,
  parameter int B_WIDTH = 8,
  parameter int W = 9,
  parameter bit SIGNED_MODE = 1'b1
) (
  input  logic [A_WIDTH-1:0] opA,
  input  logic [B_WIDTH-1:0] opB,
  output logic [W-1:0]       aExt,
  output logic [W-1:0]       bExt,
  output logic [W-1:0]       numer,
  output logic               adjust,
  output logic               divisorZero,
  output logic               numNeg,
  output logic               divNeg
);
  logic [W-1:0] bias;

  generate
    if (SIGNED_MODE) begin : g_sext
      assign aExt = {{(W-A_WIDTH){opA[A_WIDTH-1]}}, opA};
      assign bExt = {{(W-B_WIDTH){opB[B_WIDTH-1]}}, opB};
    end else begin : g_zext
      assign aExt = {{(W-A_WIDTH){1'b0}}, opA};
      assign bExt = {{(W-B_WIDTH){1'b0}}, opB};
    end
  endgenerate

  // Divisor pulled one step toward zero.
  assign bias = bExt[W-1] ? (bExt + W'(1)) : (bExt - W'(1));

  always_comb begin
    adjust = 1'b0;
    if (SIGNED_MODE)
      adjust = (aExt[W-1] != bExt[W-1]) && (aExt != '0);
  end

  assign numer       = adjust ? (aExt - bias) : aExt;
  assign divisorZero = (bExt == '0);
  assign numNeg      = SIGNED_MODE && numer[W-1];
  assign divNeg      = SIGNED_MODE && bExt[W-1];
endmodule

// File: rtl/floordiv_ctrl.sv
module floordiv_ctrl
  import floordiv_pkg::*;
#(
  parameter int W = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       divisorZero,
  output divStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  localparam int CW = $clog2(W + 1);

  divState_t state, stateNext;
  logic [CW-1:0] stepCount;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: if (start) begin
        strobe.load = 1'b1;
        stateNext   = divisorZero ? ST_FIX : ST_RUN;
      end
      ST_RUN: begin
        strobe.step = 1'b1;
        if (stepCount == CW'(W - 1)) stateNext = ST_FIX;
      end
      ST_FIX: begin
        strobe.finish = 1'b1;
        stateNext     = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      stepCount <= '0;
      done      <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobe.finish;
      if (strobe.load)      stepCount <= '0;
      else if (strobe.step) stepCount <= stepCount + CW'(1);
    end
  end

  assign busy = (state != ST_IDLE);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_run_length_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FIX && !$past(strobe.load)) |-> ($past(stepCount) == CW'(W - 1)));
  assert_idle_at_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (state == ST_IDLE));
endmodule

// File: rtl/floordiv_datapath.sv
module floordiv_datapath
  import floordiv_pkg::*;
#(
  parameter int Y_WIDTH = 8,
  parameter int W = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  divStrobe_t         strobe,
  input  logic [W-1:0]       aExt,
  input  logic [W-1:0]       bExt,
  input  logic [W-1:0]       numer,
  input  logic               adjust,
  input  logic               divisorZero,
  input  logic               numNeg,
  input  logic               divNeg,
  output logic [Y_WIDTH-1:0] quotient,
  output logic [Y_WIDTH-1:0] remainder,
  output logic               divByZero
);
  logic [W-1:0]       qSh, remAcc, magBR, magN, magB;
  logic [Y_WIDTH-1:0] aR, bR;
  logic               numNegR, divNegR, adjustR, zeroR;
  logic [W:0]         shifted, diff;
  logic [Y_WIDTH-1:0] qLow, rLow, qSigned, rTrunc, rFloor;

  assign magN = numNeg ? (W'(0) - numer) : numer;
  assign magB = divNeg ? (W'(0) - bExt) : bExt;

  // One restoring step: shift in the next dividend bit, try a subtract.
  assign shifted = {remAcc, qSh[W-1]};
  assign diff    = shifted - {1'b0, magBR};

  assign qLow    = qSh[Y_WIDTH-1:0];
  assign rLow    = remAcc[Y_WIDTH-1:0];
  assign qSigned = (numNegR ^ divNegR) ? (Y_WIDTH'(0) - qLow) : qLow;
  assign rTrunc  = numNegR ? (Y_WIDTH'(0) - rLow) : rLow;
  // Remainder of the corrected numerator mapped back onto the original dividend.
  assign rFloor  = !adjustR ? rTrunc :
                   divNegR  ? (rTrunc + bR + Y_WIDTH'(1)) :
                              (rTrunc + bR - Y_WIDTH'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qSh <= '0; remAcc <= '0; magBR <= '0;
      aR <= '0; bR <= '0;
      numNegR <= 1'b0; divNegR <= 1'b0; adjustR <= 1'b0; zeroR <= 1'b0;
      quotient <= '0; remainder <= '0; divByZero <= 1'b0;
    end else begin
      if (strobe.load) begin
        qSh     <= magN;
        remAcc  <= '0;
        magBR   <= magB;
        aR      <= aExt[Y_WIDTH-1:0];
        bR      <= bExt[Y_WIDTH-1:0];
        numNegR <= numNeg;
        divNegR <= divNeg;
        adjustR <= adjust;
        zeroR   <= divisorZero;
      end else if (strobe.step) begin
        if (!diff[W]) begin
          remAcc <= diff[W-1:0];
          qSh    <= {qSh[W-2:0], 1'b1};
        end else begin
          remAcc <= shifted[W-1:0];
          qSh    <= {qSh[W-2:0], 1'b0};
        end
      end
      if (strobe.finish) begin
        divByZero <= zeroR;
        quotient  <= zeroR ? '1 : qSigned;
        remainder <= zeroR ? aR : rFloor;
      end
    end
  end

  assert_rem_below_divisor_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && !zeroR) |-> (remAcc < magBR));
  assert_operands_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(bR) && $stable(aR) && $stable(magBR)));
  assert_results_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finish |=> ($stable(quotient) && $stable(remainder) && $stable(divByZero)));
endmodule

// File: rtl/floor_divider.sv
module floor_divider
  import floordiv_pkg::*;
#(
  parameter int A_WIDTH  = 8,
  parameter int B_WIDTH  = 8,
  parameter int Y_WIDTH  = 8,
  parameter bit A_SIGNED = 1'b1,
  parameter bit B_SIGNED = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [A_WIDTH-1:0] dividend,
  input  logic [B_WIDTH-1:0] divisor,
  output logic               busy,
  output logic               done,
  output logic [Y_WIDTH-1:0] quotient,
  output logic [Y_WIDTH-1:0] remainder,
  output logic               divByZero
);
  localparam int MAX_AB = (A_WIDTH > B_WIDTH) ? A_WIDTH : B_WIDTH;
  localparam int MAX_W  = (MAX_AB > Y_WIDTH) ? MAX_AB : Y_WIDTH;
  localparam int W      = MAX_W + 1;
  localparam bit SIGNED_MODE = A_SIGNED && B_SIGNED;

  divStrobe_t   strobe;
  logic [W-1:0] aExt, bExt, numer;
  logic         adjust, divisorZero, numNeg, divNeg;

  floordiv_prep #(.A_WIDTH(A_WIDTH), .B_WIDTH(B_WIDTH), .W(W), .SIGNED_MODE(SIGNED_MODE)) uPrep (
    .opA(dividend), .opB(divisor), .aExt(aExt), .bExt(bExt), .numer(numer),
    .adjust(adjust), .divisorZero(divisorZero), .numNeg(numNeg), .divNeg(divNeg)
  );

  floordiv_ctrl #(.W(W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .divisorZero(divisorZero),
    .strobe(strobe), .busy(busy), .done(done)
  );

  floordiv_datapath #(.Y_WIDTH(Y_WIDTH), .W(W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .aExt(aExt), .bExt(bExt),
    .numer(numer), .adjust(adjust), .divisorZero(divisorZero),
    .numNeg(numNeg), .divNeg(divNeg),
    .quotient(quotient), .remainder(remainder), .divByZero(divByZero)
  );

  assert_zero_quotient_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && divByZero) |-> (quotient == '1));
  assert_not_busy_after_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: tb/sim_floor_divider.sv
`timescale 1ns/1ps
module sim_floor_divider;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  int testsRun = 0;
  int testsFailed = 0;

  // u0: signed 4/4 -> 5, W = 6.  u1: unsigned 4/3 -> 3, W = 5.
  logic       start0 = 1'b0, start1 = 1'b0;
  logic [3:0] a0 = '0, b0 = '0, a1 = '0;
  logic [2:0] b1 = '0;
  logic       busy0, done0, dz0, busy1, done1, dz1;
  logic [4:0] q0, r0;
  logic [2:0] q1, r1;

  floor_divider #(.A_WIDTH(4), .B_WIDTH(4), .Y_WIDTH(5), .A_SIGNED(1'b1), .B_SIGNED(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .start(start0), .dividend(a0), .divisor(b0),
    .busy(busy0), .done(done0), .quotient(q0), .remainder(r0), .divByZero(dz0));

  floor_divider #(.A_WIDTH(4), .B_WIDTH(3), .Y_WIDTH(3), .A_SIGNED(1'b0), .B_SIGNED(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .start(start1), .dividend(a1), .divisor(b1),
    .busy(busy1), .done(done1), .quotient(q1), .remainder(r1), .divByZero(dz1));

  task automatic check(input bit ok, input string tag, input int a, input int b,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", tag, a, b, act, exp);
    end
  endtask

  task automatic waitDone0(output int cyc);
    cyc = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      start0 = 1'b0;
      cyc++;
      if (done0) return;
    end
  endtask

  task automatic waitDone1(output int cyc);
    cyc = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      start1 = 1'b0;
      cyc++;
      if (done1) return;
    end
  endtask

  task automatic runSigned(input int a, input int b);
    int q, r, cyc, expCyc;
    logic [4:0] eq, er;
    a0 = 4'(a); b0 = 4'(b); start0 = 1'b1;
    waitDone0(cyc);
    if (b == 0) begin
      eq = 5'h1f; er = 5'(a); expCyc = 2;
      check(dz0 == 1'b1, "R5 flag", a, b, int'(dz0), 1);
      check(q0 == eq, "R5 quotient", a, b, int'(q0), int'(eq));
      check(r0 == er, "R5 remainder", a, b, int'(r0), int'(er));
    end else begin
      q = a / b; r = a % b;
      if (r != 0 && ((r < 0) != (b < 0))) begin q = q - 1; r = r + b; end
      eq = 5'(q); er = 5'(r); expCyc = 8;
      check(dz0 == 1'b0, "R5 flag clear", a, b, int'(dz0), 0);
      if (a == -8 && b == -1)
        check(q0 == eq, "R10 quotient", a, b, int'(q0), int'(eq));
      else
        check(q0 == eq, "R1 quotient", a, b, int'(q0), int'(eq));
      check(r0 == er, "R2 remainder", a, b, int'(r0), int'(er));
    end
    check(cyc == expCyc, "R6 latency", a, b, cyc, expCyc);
    @(negedge clk);
    check(done0 == 1'b0, "R6 single pulse", a, b, int'(done0), 0);
  endtask

  task automatic runUnsigned(input int a, input int b);
    int cyc, expCyc;
    logic [2:0] eq, er;
    a1 = 4'(a); b1 = 3'(b); start1 = 1'b1;
    waitDone1(cyc);
    if (b == 0) begin
      eq = 3'h7; er = 3'(a); expCyc = 2;
      check(dz1 == 1'b1, "R5 flag", a, b, int'(dz1), 1);
      check(q1 == eq, "R5 quotient", a, b, int'(q1), int'(eq));
      check(r1 == er, "R5 remainder", a, b, int'(r1), int'(er));
    end else begin
      eq = 3'(a / b); er = 3'(a % b); expCyc = 7;
      if (a / b > 7)
        check(q1 == eq, "R4 wrapped quotient", a, b, int'(q1), int'(eq));
      else
        check(q1 == eq, "R3 quotient", a, b, int'(q1), int'(eq));
      check(r1 == er, "R3 remainder", a, b, int'(r1), int'(er));
    end
    check(cyc == expCyc, "R6 latency", a, b, cyc, expCyc);
  endtask

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(busy0 == 0 && done0 == 0 && dz0 == 0, "R9 status", 0, 0, int'({busy0, done0, dz0}), 0);
    check(q0 == 0 && r0 == 0, "R9 results", 0, 0, int'({q0, r0}), 0);
    check(busy1 == 0 && done1 == 0 && q1 == 0 && r1 == 0, "R9 unsigned unit", 0, 0,
          int'({busy1, done1, q1, r1}), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int a = -8; a < 8; a++)
      for (int b = -8; b < 8; b++)
        runSigned(a, b);
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 8; b++)
        runUnsigned(a, b);

    // R7: start and operand changes while busy are ignored
    a0 = 4'(7); b0 = 4'(-2); start0 = 1'b1;
    @(negedge clk); start0 = 1'b0;
    @(negedge clk);
    check(busy0 == 1'b1, "R7 busy", 7, -2, int'(busy0), 1);
    a0 = 4'(1); b0 = 4'(0); start0 = 1'b1;
    @(negedge clk); start0 = 1'b0;
    waitDone0(cyc);
    check(cyc + 3 == 8, "R7 latency unchanged", 7, -2, cyc + 3, 8);
    check(q0 == 5'(-4), "R7 quotient", 7, -2, int'(q0), -4 & 31);
    check(r0 == 5'(-1), "R7 remainder", 7, -2, int'(r0), -1 & 31);
    check(dz0 == 1'b0, "R7 flag", 7, -2, int'(dz0), 0);

    // R8: results hold while idle and while operands change
    a0 = 4'(3); b0 = 4'(1);
    repeat (5) @(negedge clk);
    check(q0 == 5'(-4) && r0 == 5'(-1), "R8 hold", 7, -2, int'({q0, r0}), int'({5'(-4), 5'(-1)}));

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule